// File: doc/BRIEF.md
# Dual-Mode Floating-Point Register File

This block holds the 32 floating-point registers of a processor core and serves them by data format rather than as raw words. Every port carries a register index and a three-bit format code (single, word, double, long, paired-single). The shared storage is viewed in one of two ways. The choice comes from a run-time mode input, which is driven by a status-register bit outside the block. In narrow mode there are 32 registers of 32 bits, and a 64-bit double is split across an even/odd pair. In wide mode there are 32 registers of 64 bits, and any 64-bit format may sit in any register.

The block has two combinational read ports and one write port that updates on the clock edge. An access that the selected mode cannot honour raises a per-port illegal-access flag. An illegal read returns zero. An illegal write leaves every register untouched. The same storage backs both modes: narrow register k is the low 32 bits of wide register k. Software may therefore switch modes and still see its low halves.

Top module: `fprf_dual_mode`

## Requirements
- R1: After reset every register holds zero, so a legal read of any index in any mode returns zero with the flag low.
- R2: In narrow mode a single (code 0) or word (code 1) write stores bits 31:0 of the write data in register idx. A single or word read returns that register in bits 31:0 with bits 63:32 zero.
- R3: In narrow mode a double (code 2) access at an even idx covers the pair. Register idx+1 holds bits 63:32 and register idx holds bits 31:0, and each half reads back individually as a single.
- R4: In wide mode double (code 2), long (code 3) and paired-single (code 4) read and write all 64 bits of register idx, for even and odd idx alike.
- R5: In narrow mode long and paired-single accesses are illegal. The port flag is set, read data is zero, and a write changes no register.
- R6: In narrow mode a double access at an odd idx is illegal, with the same flag, zero-data and no-write behaviour as R5.
- R7: Format codes 5, 6 and 7 are illegal in both modes, with the same flag, zero-data and no-write behaviour.
- R8: In wide mode a single or word write replaces bits 31:0 of register idx and keeps bits 63:32. A single or word read returns bits 31:0 zero-extended.
- R9: Reads are combinational. A write takes effect at the rising clock edge, so a read of the written register in the same cycle returns the old value.
- R10: The two read ports are independent. The write flag is raised only while the write enable is high.
- R11: Narrow register k and bits 31:0 of wide register k are the same storage. Changing the mode alters no stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode | input | 1 | 1 selects 64-bit registers, 0 selects 32-bit registers |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_fmt | input | 3 | Read port 0 format code |
| rd0_data | output | 64 | Read port 0 data |
| rd0_bad | output | 1 | Read port 0 illegal-access flag |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_fmt | input | 3 | Read port 1 format code |
| rd1_data | output | 64 | Read port 1 data |
| rd1_bad | output | 1 | Read port 1 illegal-access flag |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_fmt | input | 3 | Write format code |
| wr_data | input | 64 | Write data |
| wr_bad | output | 1 | Write illegal-access flag |

## Verification
Read data and both kinds of illegal-access flag are combinational, so they are due in the same cycle as the stimulus that selects them. A write is due one rising edge later. The bench drives each step on the falling edge and samples the combinational results one time unit later. The effect of a write is read in the step after it, and the same step also reads the old value to confirm that the write has not yet landed. Every "no write happened" claim is checked through a later legal read of the register that an illegal write would have touched.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    localparam int FMT_W = 3;

    typedef enum logic [FMT_W-1:0] {
        FMT_SGL = 3'd0,
        FMT_WRD = 3'd1,
        FMT_DBL = 3'd2,
        FMT_LNG = 3'd3,
        FMT_PSG = 3'd4
    } fp_fmt_e;

    // Decoded view of one access
    typedef struct packed {
        logic legal;    // access permitted in the current mode
        logic full64;   // format carries 64 bits
        logic paired;   // 64-bit value split over an even/odd pair
    } acc_dec_t;

    function automatic acc_dec_t decode_access(input logic wide,
                                               input logic [FMT_W-1:0] fmt,
                                               input logic idx_lsb);
        acc_dec_t d;
        logic known;
        known    = (fmt <= FMT_PSG);
        d.full64 = (fmt == FMT_DBL) || (fmt == FMT_LNG) || (fmt == FMT_PSG);
        d.paired = !wide && (fmt == FMT_DBL);
        if (!known) begin
            d.legal = 1'b0;
        end else if (wide) begin
            d.legal = 1'b1;
        end else begin
            d.legal = !((fmt == FMT_LNG) || (fmt == FMT_PSG) ||
                        ((fmt == FMT_DBL) && idx_lsb));
        end
        return d;
    endfunction

endpackage

// File: rtl/fprf_access_dec.sv
module fprf_access_dec
    import fprf_pkg::*;
(
    input  logic             wide_mode,
    input  logic [FMT_W-1:0] fmt,
    input  logic             idx_lsb,
    output acc_dec_t         dec
);
    always_comb begin
        dec = decode_access(wide_mode, fmt, idx_lsb);
    end
endmodule

// File: rtl/fprf_read_port.sv
module fprf_read_port
    import fprf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int HALF_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int WORD_W  = 2 * HALF_W
) (
    input  logic                             wide_mode,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [FMT_W-1:0]                 fmt,
    input  logic [NUM_REGS-1:0][HALF_W-1:0]  lo_bank,
    input  logic [NUM_REGS-1:0][HALF_W-1:0]  hi_bank,
    output logic [WORD_W-1:0]                data,
    output logic                             bad
);
    acc_dec_t         dec;
    logic [IDX_W-1:0] partner;

    fprf_access_dec u_dec (
        .wide_mode (wide_mode),
        .fmt       (fmt),
        .idx_lsb   (idx[0]),
        .dec       (dec)
    );

    always_comb begin
        partner = {idx[IDX_W-1:1], 1'b1};
        bad     = !dec.legal;
        data    = '0;
        if (dec.legal) begin
            if (!dec.full64) begin
                data = {{HALF_W{1'b0}}, lo_bank[idx]};
            end else if (dec.paired) begin
                data = {lo_bank[partner], lo_bank[idx]};
            end else begin
                data = {hi_bank[idx], lo_bank[idx]};
            end
        end
    end
endmodule

// File: rtl/fprf_write_ctrl.sv
module fprf_write_ctrl
    import fprf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int HALF_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int WORD_W  = 2 * HALF_W
) (
    input  logic                             wide_mode,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [FMT_W-1:0]                 fmt,
    input  logic [WORD_W-1:0]                wdata,
    output logic [NUM_REGS-1:0]              lo_we,
    output logic [NUM_REGS-1:0][HALF_W-1:0]  lo_wdata,
    output logic [NUM_REGS-1:0]              hi_we,
    output logic [HALF_W-1:0]                hi_wdata,
    output logic                             bad
);
    acc_dec_t         dec;
    logic             commit;
    logic [IDX_W-1:0] partner;

    fprf_access_dec u_dec (
        .wide_mode (wide_mode),
        .fmt       (fmt),
        .idx_lsb   (idx[0]),
        .dec       (dec)
    );

    always_comb begin
        commit   = we && dec.legal;
        bad      = we && !dec.legal;
        partner  = {idx[IDX_W-1:1], 1'b1};
        hi_wdata = wdata[WORD_W-1:HALF_W];
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_comb begin
            lo_we[r] = commit && ((IDX_W'(r) == idx) ||
                                  (dec.paired && (IDX_W'(r) == partner)));
            lo_wdata[r] = (dec.paired && (r % 2 == 1)) ?
                          wdata[WORD_W-1:HALF_W] : wdata[HALF_W-1:0];
            hi_we[r] = commit && wide_mode && dec.full64 && (IDX_W'(r) == idx);
        end
    end
endmodule

// File: rtl/fprf_dual_mode.sv
module fprf_dual_mode
    import fprf_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int HALF_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int WORD_W  = 2 * HALF_W,
    localparam int NUM_RD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [FMT_W-1:0]  rd0_fmt,
    output logic [WORD_W-1:0] rd0_data,
    output logic              rd0_bad,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [FMT_W-1:0]  rd1_fmt,
    output logic [WORD_W-1:0] rd1_data,
    output logic              rd1_bad,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [FMT_W-1:0]  wr_fmt,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_bad
);
    typedef struct packed {
        logic [NUM_REGS-1:0][HALF_W-1:0] lo;
        logic [NUM_REGS-1:0][HALF_W-1:0] hi;
    } bank_t;

    bank_t state_d, state_q;

    logic [NUM_REGS-1:0]             lo_we_d;
    logic [NUM_REGS-1:0][HALF_W-1:0] lo_wdata_d;
    logic [NUM_REGS-1:0]             hi_we_d;
    logic [HALF_W-1:0]               hi_wdata_d;

    logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
    logic [NUM_RD-1:0][FMT_W-1:0]  rd_fmt;
    logic [NUM_RD-1:0][WORD_W-1:0] rd_data;
    logic [NUM_RD-1:0]             rd_bad;

    always_comb begin
        rd_idx[0] = rd0_idx;
        rd_fmt[0] = rd0_fmt;
        rd_idx[1] = rd1_idx;
        rd_fmt[1] = rd1_fmt;
        rd0_data  = rd_data[0];
        rd0_bad   = rd_bad[0];
        rd1_data  = rd_data[1];
        rd1_bad   = rd_bad[1];
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        fprf_read_port #(
            .NUM_REGS (NUM_REGS),
            .HALF_W   (HALF_W)
        ) u_rd (
            .wide_mode (wide_mode),
            .idx       (rd_idx[p]),
            .fmt       (rd_fmt[p]),
            .lo_bank   (state_q.lo),
            .hi_bank   (state_q.hi),
            .data      (rd_data[p]),
            .bad       (rd_bad[p])
        );
    end

    fprf_write_ctrl #(
        .NUM_REGS (NUM_REGS),
        .HALF_W   (HALF_W)
    ) u_wr (
        .wide_mode (wide_mode),
        .we        (wr_en),
        .idx       (wr_idx),
        .fmt       (wr_fmt),
        .wdata     (wr_data),
        .lo_we     (lo_we_d),
        .lo_wdata  (lo_wdata_d),
        .hi_we     (hi_we_d),
        .hi_wdata  (hi_wdata_d),
        .bad       (wr_bad)
    );

    always_comb begin
        state_d = state_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (lo_we_d[r]) begin
                state_d.lo[r] = lo_wdata_d[r];
            end
            if (hi_we_d[r]) begin
                state_d.hi[r] = hi_wdata_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/fprf_dual_mode_chk.sv
module fprf_dual_mode_chk
    import fprf_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_mode,
    input logic [IDX_W-1:0]  rd0_idx,
    input logic [FMT_W-1:0]  rd0_fmt,
    input logic [WORD_W-1:0] rd0_data,
    input logic              rd0_bad,
    input logic [IDX_W-1:0]  rd1_idx,
    input logic [FMT_W-1:0]  rd1_fmt,
    input logic [WORD_W-1:0] rd1_data,
    input logic              rd1_bad,
    input logic              wr_en,
    input logic [FMT_W-1:0]  wr_fmt,
    input logic              wr_bad
);
    a_r5_narrow_wide_fmt_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && (rd0_fmt == FMT_LNG || rd0_fmt == FMT_PSG))
        |-> (rd0_bad && rd0_data == '0));

    a_r5_narrow_wide_fmt_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && wr_en && (wr_fmt == FMT_LNG || wr_fmt == FMT_PSG)) |-> wr_bad);

    a_r6_odd_pair_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && rd1_fmt == FMT_DBL && rd1_idx[0]) |-> (rd1_bad && rd1_data == '0));

    a_r7_unknown_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_fmt > FMT_PSG) |-> rd0_bad);

    a_r10_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_bad);

    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en ##1 ($stable(rd1_idx) && $stable(rd1_fmt) && $stable(wide_mode))
        |-> $stable(rd1_data));
endmodule

bind fprf_dual_mode fprf_dual_mode_chk #(
    .IDX_W  (IDX_W),
    .WORD_W (WORD_W)
) u_chk (.*);

// File: tb/fprf_dual_mode_tb.sv
module fprf_dual_mode_tb_top;

    typedef struct packed {
        logic [3:0]  req;
        logic        mode;
        logic        we;
        logic [4:0]  widx;
        logic [2:0]  wfmt;
        logic [63:0] wdat;
        logic        wbad;
        logic [4:0]  ridx;
        logic [2:0]  rfmt;
        logic [63:0] rexp;
        logic        rbad;
    } vec_t;

    localparam int NV = 20;
    // Format codes: 0 single, 1 word, 2 double, 3 long, 4 paired-single
    localparam vec_t VEC [NV] = '{
        // R9: read before the write lands
        '{4'd9, 1'b0, 1'b1, 5'd3, 3'd0, 64'hFFFF0000_AABBCCDD, 1'b0, 5'd3, 3'd0, 64'h0, 1'b0},
        // R2
        '{4'd2, 1'b0, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd3, 3'd0, 64'h00000000_AABBCCDD, 1'b0},
        // R9
        '{4'd9, 1'b0, 1'b1, 5'd4, 3'd2, 64'h11223344_55667788, 1'b0, 5'd4, 3'd2, 64'h0, 1'b0},
        // R3
        '{4'd3, 1'b0, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd4, 3'd2, 64'h11223344_55667788, 1'b0},
        // R3 upper half in odd partner
        '{4'd3, 1'b0, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd5, 3'd0, 64'h00000000_11223344, 1'b0},
        // R6
        '{4'd6, 1'b0, 1'b1, 5'd7, 3'd2, 64'hDEADBEEF_DEADBEEF, 1'b1, 5'd7, 3'd2, 64'h0, 1'b1},
        // R6 no write
        '{4'd6, 1'b0, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd7, 3'd1, 64'h0, 1'b0},
        // R5
        '{4'd5, 1'b0, 1'b1, 5'd10, 3'd3, 64'h12345678_9ABCDEF0, 1'b1, 5'd10, 3'd4, 64'h0, 1'b1},
        // R5 no write
        '{4'd5, 1'b0, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd10, 3'd1, 64'h0, 1'b0},
        // R7
        '{4'd7, 1'b0, 1'b1, 5'd12, 3'd5, 64'h0BAD0BAD_0BAD0BAD, 1'b1, 5'd3, 3'd6, 64'h0, 1'b1},
        // R11 mode change keeps low halves
        '{4'd11, 1'b1, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd4, 3'd2, 64'h00000000_55667788, 1'b0},
        // R11
        '{4'd11, 1'b1, 1'b1, 5'd9, 3'd3, 64'hCAFEF00D_12345678, 1'b0, 5'd3, 3'd0, 64'h00000000_AABBCCDD, 1'b0},
        // R4 odd index, long then paired
        '{4'd4, 1'b1, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd9, 3'd4, 64'hCAFEF00D_12345678, 1'b0},
        // R9
        '{4'd9, 1'b1, 1'b1, 5'd9, 3'd0, 64'hFFFFFFFF_87654321, 1'b0, 5'd9, 3'd3, 64'hCAFEF00D_12345678, 1'b0},
        // R8 upper kept
        '{4'd8, 1'b1, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd9, 3'd2, 64'hCAFEF00D_87654321, 1'b0},
        // R8 zero-extended single read
        '{4'd8, 1'b1, 1'b1, 5'd1, 3'd4, 64'h01020304_05060708, 1'b0, 5'd9, 3'd0, 64'h00000000_87654321, 1'b0},
        // R4
        '{4'd4, 1'b1, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd1, 3'd4, 64'h01020304_05060708, 1'b0},
        // R3 narrow pair built from registers 0 and 1
        '{4'd3, 1'b0, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd0, 3'd2, 64'h05060708_00000000, 1'b0},
        // R7 wide mode
        '{4'd7, 1'b1, 1'b1, 5'd2, 3'd7, 64'hFFFFFFFF_FFFFFFFF, 1'b1, 5'd1, 3'd1, 64'h00000000_05060708, 1'b0},
        // R7 no write
        '{4'd7, 1'b1, 1'b0, 5'd0, 3'd0, 64'h0, 1'b0, 5'd2, 3'd2, 64'h0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [4:0]  rd0_idx = '0;
    logic [2:0]  rd0_fmt = '0;
    logic [63:0] rd0_data;
    logic        rd0_bad;
    logic [4:0]  rd1_idx = '0;
    logic [2:0]  rd1_fmt = '0;
    logic [63:0] rd1_data;
    logic        rd1_bad;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [2:0]  wr_fmt = '0;
    logic [63:0] wr_data = '0;
    logic        wr_bad;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fprf_dual_mode dut_i (
        .clk (clk), .rst_n (rst_n), .wide_mode (wide_mode),
        .rd0_idx (rd0_idx), .rd0_fmt (rd0_fmt), .rd0_data (rd0_data), .rd0_bad (rd0_bad),
        .rd1_idx (rd1_idx), .rd1_fmt (rd1_fmt), .rd1_data (rd1_data), .rd1_bad (rd1_bad),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_fmt (wr_fmt), .wr_data (wr_data),
        .wr_bad (wr_bad)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen through both ports
        rd0_idx = 5'd4; rd0_fmt = 3'd2;
        rd1_idx = 5'd31; rd1_fmt = 3'd1;
        #1;
        chk("R1 rd0 data after reset", rd0_data, 64'h0);
        chk("R1 rd0 flag after reset", {63'h0, rd0_bad}, 64'h0);
        chk("R1 rd1 data after reset", rd1_data, 64'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wide_mode = VEC[i].mode;
            wr_en     = VEC[i].we;
            wr_idx    = VEC[i].widx;
            wr_fmt    = VEC[i].wfmt;
            wr_data   = VEC[i].wdat;
            rd0_idx   = VEC[i].ridx;
            rd0_fmt   = VEC[i].rfmt;
            rd1_idx   = 5'd0;
            rd1_fmt   = 3'd0;
            #1;
            chk($sformatf("R%0d vec %0d read data", VEC[i].req, i), rd0_data, VEC[i].rexp);
            chk($sformatf("R%0d vec %0d read flag", VEC[i].req, i), {63'h0, rd0_bad}, {63'h0, VEC[i].rbad});
            chk($sformatf("R%0d vec %0d write flag", VEC[i].req, i), {63'h0, wr_bad}, {63'h0, VEC[i].wbad});
        end

        // R10: both read ports at once, and no write flag without enable
        @(negedge clk);
        wide_mode = 1'b1;
        wr_en = 1'b0; wr_fmt = 3'd5; wr_idx = 5'd2;
        rd0_idx = 5'd9; rd0_fmt = 3'd2;
        rd1_idx = 5'd1; rd1_fmt = 3'd4;
        #1;
        chk("R10 rd0 independent", rd0_data, 64'hCAFEF00D_87654321);
        chk("R10 rd1 independent", rd1_data, 64'h01020304_05060708);
        chk("R10 rd1 flag", {63'h0, rd1_bad}, 64'h0);
        chk("R10 write flag without enable", {63'h0, wr_bad}, 64'h0);

        // R6 on port 1 in narrow mode
        @(negedge clk);
        wide_mode = 1'b0;
        rd1_idx = 5'd5; rd1_fmt = 3'd2;
        #1;
        chk("R6 rd1 odd double data", rd1_data, 64'h0);
        chk("R6 rd1 odd double flag", {63'h0, rd1_bad}, 64'h1);

        // R1: reset clears written registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wide_mode = 1'b1;
        rd0_idx = 5'd9; rd0_fmt = 3'd2;
        rd1_idx = 5'd1; rd1_fmt = 3'd4;
        #1;
        chk("R1 rd0 cleared by reset", rd0_data, 64'h0);
        chk("R1 rd1 cleared by reset", rd1_data, 64'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule